// File: doc/BRIEF.md
# Opcode Lookahead Fetch Sequencer

This block is the instruction front end of a small 8-bit controller core. It owns the 16-bit program counter and a byte-wide read port to program memory, and it keeps the bus busy on every cycle. In the non-final cycles of an instruction it reads that instruction's operand bytes. In the final cycle it reads the opcode of the following instruction into a lookahead register. Because of this overlap, the next instruction begins on the very next cycle with no idle bus cycle between the two.

The opcode held in the lookahead register goes to the decode logic through the `opcode` output. A built-in length decode gives the number of bus cycles for each opcode. Two strobes mark the sequence. One flags every cycle that reads an opcode. The other flags the closing cycle of the running instruction. A position counter, `busCycle`, tells the execution side which cycle of the instruction is under way. After reset, a single opcode-only read loads the first opcode before any instruction starts counting.

Top module: `opfetch_seq`

## Requirements
- R1: While `rst` is high, `memRdEn`, `lookaheadStrobe` and `lastStrobe` are all 0. On the first cycle after `rst` falls, `memAddr` equals the `resetVector` value that was present while reset was applied.
- R2: The first cycle after reset is a fill cycle. It reads the opcode at the reset vector with `lookaheadStrobe` = 1 and `lastStrobe` = 0.
- R3: An instruction whose opcode has bits [1:0] = k takes exactly k+1 bus cycles. `lastStrobe` is 1 in the last of those cycles and in no other cycle.
- R4: `lookaheadStrobe` is 1 in every cycle where `lastStrobe` is 1. The byte read in such a cycle appears on `opcode` in the next cycle.
- R5: Once reset is released, `memRdEn` is 1 on every cycle. `memAddr` rises by exactly one per cycle and wraps from 16'hFFFF to 16'h0000.
- R6: In the cycle after any opcode read, `memAddr` points one byte past the address of that opcode.
- R7: `opcode` keeps its value in every cycle that does not follow an opcode read.
- R8: `busCycle` is 1 in the first cycle of each instruction and rises by one each cycle up to the instruction's length.
- R9: Raising `rst` in the middle of an instruction abandons it. After release, the sequence restarts with a fill cycle at the new reset vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bus cycle is one clock cycle |
| rst | input | 1 | Synchronous active-high reset |
| resetVector | input | 16 | Start address loaded into the program counter during reset |
| memAddr | output | 16 | Read address (current program counter) |
| memRdEn | output | 1 | Read request, high on every cycle outside reset |
| memRdData | input | 8 | Byte returned from `memAddr` in the same cycle |
| opcode | output | 8 | Lookahead opcode handed to decode |
| busCycle | output | 3 | Position of the current cycle within the running instruction |
| lookaheadStrobe | output | 1 | High in every cycle that reads an opcode |
| lastStrobe | output | 1 | High in the final cycle of the running instruction |

## Verification
A bad cycle counter or length decode is visible at the ports on the very cycle it goes wrong. `lastStrobe` rises early or late, and from then on every `opcode` value and every `busCycle` value disagrees with the reference model. A program counter that skips or stalls shows up on `memAddr` within one cycle. A lookahead register that captures at the wrong edge presents a wrong `opcode` on the first cycle of the next instruction. Runs made only of single-cycle opcodes, runs made only of four-cycle opcodes, mixed byte streams, address wraparound and reset in mid-instruction each force these faults to appear.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  // sequencer phase: a single opcode-only fill after reset, then normal execution
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_RUN  = 1'b1
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic busRead;    // one memory read this cycle, pc advances
    logic prefetch;   // the byte read this cycle is an opcode
    logic lastCycle;  // closing cycle of the running instruction
  } ctlStrobesT;

endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
#(
  parameter int MaxCycles = 4,
  localparam int LenBits = $clog2(MaxCycles),
  localparam int CntW    = $clog2(MaxCycles + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LenBits-1:0] lenField,
  output ctlStrobesT         ctl,
  output logic [CntW-1:0]    busCycle
);

  seqStateT        state;
  logic [CntW-1:0] cycleCnt;
  logic [CntW-1:0] instLen;
  logic            atLast;

  // length decode: the low opcode field holds (cycles - 1)
  always_comb instLen = CntW'(lenField) + CntW'(1);

  always_comb atLast = (state == ST_RUN) && (cycleCnt == instLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FILL;
      cycleCnt <= CntW'(1);
    end else begin
      unique case (state)
        ST_FILL: begin
          state    <= ST_RUN;
          cycleCnt <= CntW'(1);
        end
        ST_RUN: begin
          if (atLast) cycleCnt <= CntW'(1);
          else        cycleCnt <= cycleCnt + CntW'(1);
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    if (!rst) begin
      ctl.busRead   = 1'b1;
      ctl.prefetch  = (state == ST_FILL) || atLast;
      ctl.lastCycle = atLast;
    end
  end

  assign busCycle = cycleCnt;

endmodule

// File: rtl/opfetch_dp.sv
module opfetch_dp
  import opfetch_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] resetVector,
  input  ctlStrobesT       ctl,
  input  logic [DataW-1:0] memRdData,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] opcode
);

  logic [AddrW-1:0] pcReg;
  logic [DataW-1:0] lookaheadReg;

  always_ff @(posedge clk) begin
    if (rst)              pcReg <= resetVector;
    else if (ctl.busRead) pcReg <= pcReg + AddrW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst && ctl.prefetch) lookaheadReg <= memRdData;
  end

  assign memAddr = pcReg;
  assign opcode  = lookaheadReg;

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int AddrW     = 16,
  parameter int DataW     = 8,
  parameter int MaxCycles = 4,
  localparam int LenBits  = $clog2(MaxCycles),
  localparam int CntW     = $clog2(MaxCycles + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] resetVector,
  output logic [AddrW-1:0] memAddr,
  output logic             memRdEn,
  input  logic [DataW-1:0] memRdData,
  output logic [DataW-1:0] opcode,
  output logic [CntW-1:0]  busCycle,
  output logic             lookaheadStrobe,
  output logic             lastStrobe
);

  ctlStrobesT ctl;

  opfetch_ctrl #(
    .MaxCycles(MaxCycles)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lenField (opcode[LenBits-1:0]),
    .ctl      (ctl),
    .busCycle (busCycle)
  );

  opfetch_dp #(
    .AddrW(AddrW),
    .DataW(DataW)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .resetVector (resetVector),
    .ctl         (ctl),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .opcode      (opcode)
  );

  assign memRdEn         = ctl.busRead;
  assign lookaheadStrobe = ctl.prefetch;
  assign lastStrobe      = ctl.lastCycle;

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int AddrW     = 16,
  parameter int DataW     = 8,
  parameter int MaxCycles = 4,
  localparam int LenBits  = $clog2(MaxCycles),
  localparam int CntW     = $clog2(MaxCycles + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [AddrW-1:0] resetVector,
  input logic [AddrW-1:0] memAddr,
  input logic             memRdEn,
  input logic [DataW-1:0] memRdData,
  input logic [DataW-1:0] opcode,
  input logic [CntW-1:0]  busCycle,
  input logic             lookaheadStrobe,
  input logic             lastStrobe
);

  logic [CntW-1:0] specLen;
  always_comb specLen = CntW'(opcode[LenBits-1:0]) + CntW'(1);

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> (!memRdEn && !lookaheadStrobe && !lastStrobe));

  assert_start_at_vector_R9: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (memAddr == $past(resetVector)));

  assert_last_at_length_R3: assert property (@(posedge clk) disable iff (rst)
    lastStrobe |-> (busCycle == specLen));

  assert_last_prefetches_R4: assert property (@(posedge clk) disable iff (rst)
    lastStrobe |-> lookaheadStrobe);

  assert_opcode_arrives_R4: assert property (@(posedge clk) disable iff (rst)
    $past(lookaheadStrobe) |-> ((opcode == $past(memRdData)) && (busCycle == CntW'(1))));

  assert_pc_steps_R5: assert property (@(posedge clk) disable iff (rst)
    $past(memRdEn) |-> (memRdEn && (memAddr == $past(memAddr) + AddrW'(1))));

  assert_opcode_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(memRdEn) && !$past(lookaheadStrobe)) |-> $stable(opcode));

  assert_cycle_counts_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(memRdEn) && !$past(lookaheadStrobe)) |-> (busCycle == $past(busCycle) + CntW'(1)));

endmodule

bind opfetch_seq opfetch_seq_chk #(
  .AddrW(AddrW),
  .DataW(DataW),
  .MaxCycles(MaxCycles)
) u_chk (.*);

// File: tb/sim_opfetch_seq.sv
module sim_opfetch_seq;

  localparam int ClkPeriod = 10;
  localparam int AddrW     = 16;
  localparam int DataW     = 8;
  localparam int MaxCycles = 4;
  localparam int CntW      = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AddrW-1:0] resetVector = 16'h0100;
  logic [AddrW-1:0] memAddr;
  logic             memRdEn;
  logic [DataW-1:0] memRdData;
  logic [DataW-1:0] opcode;
  logic [CntW-1:0]  busCycle;
  logic             lookaheadStrobe;
  logic             lastStrobe;

  logic [7:0] memArr [256];

  always #(ClkPeriod/2) clk = ~clk;

  assign memRdData = memArr[memAddr[7:0]];

  opfetch_seq #(
    .AddrW(AddrW), .DataW(DataW), .MaxCycles(MaxCycles)
  ) u0 (
    .clk(clk), .rst(rst), .resetVector(resetVector),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .opcode(opcode), .busCycle(busCycle),
    .lookaheadStrobe(lookaheadStrobe), .lastStrobe(lastStrobe)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference state
  logic [15:0] mPc;
  logic [7:0]  mOp;
  int          mCnt;
  bit          mFill;
  bit          prevPref;
  logic [15:0] prevPrefAddr;
  bit          prevRst;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fillMem(input int mode);
    for (int i = 0; i < 256; i++) begin
      case (mode)
        0:       memArr[i] = 8'((i * 29 + 7) ^ (i >> 3));
        1:       memArr[i] = 8'h40;   // low field 0: one-cycle opcodes
        default: memArr[i] = 8'hF3;   // low field 3: four-cycle opcodes
      endcase
    end
  endtask

  task automatic step(input bit r);
    int  len;
    bit  expLook, expLast;
    @(negedge clk);
    rst = r;
    #1;
    len = int'(mOp[1:0]) + 1;
    expLook = mFill || (mCnt == len);
    expLast = !mFill && (mCnt == len);
    if (rst) begin
      check(!memRdEn && !lookaheadStrobe && !lastStrobe, "R1", "strobes in reset",
            {memRdEn, lookaheadStrobe, lastStrobe}, 0);
    end else begin
      check(memRdEn == 1'b1, "R5", "memRdEn", memRdEn, 1);
      check(memAddr == mPc, "R5", "memAddr", memAddr, mPc);
      if (prevRst)
        check(memAddr == resetVector, "R9", "restart address", memAddr, resetVector);
      if (prevPref)
        check(memAddr == prevPrefAddr + 16'd1, "R6", "pc past opcode", memAddr, prevPrefAddr + 16'd1);
      if (mFill) begin
        check(lookaheadStrobe && !lastStrobe, "R2", "fill strobes",
              {lookaheadStrobe, lastStrobe}, 2'b10);
      end else begin
        check(lastStrobe == expLast, "R3", "lastStrobe", lastStrobe, expLast);
        check(lookaheadStrobe == expLook, "R4", "lookaheadStrobe", lookaheadStrobe, expLook);
        check(opcode == mOp, "R7", "opcode", opcode, mOp);
        check(int'(busCycle) == mCnt, "R8", "busCycle", busCycle, mCnt);
      end
    end
    // advance the reference to the next edge
    prevPref     = !rst && expLook;
    prevPrefAddr = memAddr;
    prevRst      = rst;
    if (rst) begin
      mPc   = resetVector;
      mFill = 1;
      mCnt  = 1;
    end else if (mFill) begin
      mOp   = memArr[mPc[7:0]];
      mPc   = mPc + 16'd1;
      mFill = 0;
      mCnt  = 1;
    end else begin
      if (mCnt == len) begin
        mOp  = memArr[mPc[7:0]];
        mCnt = 1;
      end else begin
        mCnt = mCnt + 1;
      end
      mPc = mPc + 16'd1;
    end
  endtask

  initial begin
    #(ClkPeriod * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    mPc = '0; mOp = '0; mCnt = 1; mFill = 1;
    prevPref = 0; prevPrefAddr = '0; prevRst = 0;
    fillMem(0);
    // R1, R2: reset then fill, mixed lengths
    resetVector = 16'h0100;
    repeat (3) step(1'b1);
    repeat (200) step(1'b0);
    // R9: reset mid-instruction, vector near the top of the address space (R5 wrap)
    resetVector = 16'hFFFD;
    repeat (2) step(1'b1);
    fillMem(1);           // R3: back-to-back single-cycle instructions
    repeat (60) step(1'b0);
    resetVector = 16'h0020;
    fillMem(2);           // R3, R8: four-cycle instructions
    step(1'b1);
    repeat (60) step(1'b0);
    // mixed stream again, reset applied for a single cycle
    fillMem(0);
    resetVector = 16'h0077;
    step(1'b1);
    repeat (150) step(1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule